// File: doc/BRIEF.md
# Boot-Block Flash Array Controller

This block is a synthesizable behavioural model of a boot-block flash memory with a scaled-down storage array. The array is cut into erase blocks of uneven size. There is one small lockable boot block, two parameter blocks, one mid-size main block and a parameterized number of full-size main blocks. A strap chosen at reset puts the boot block either at address zero or at the top of the map. A second strap selects byte-wide or word-wide access.

Program and block-erase run only after a two-write command sequence on a simple synchronous write port. An internal state machine then performs the work. Programming can only clear bits. Erase walks the addressed block one word per cycle and sets every bit. A status register reports ready/busy and sticky error flags. Operations are refused when the programming-voltage-low flag is raised. They are also refused when they target the boot block while neither unlock input is active.

Top module: `bootblk_flash`

## Requirements
- R1: After reset the block is in read-array mode. The 0x70 command then shows status 0x80 (ready, no errors). Array contents survive a reset.
- R2: Block sizes in bytes are 16384/SCALE (boot), 8192/SCALE (each of two parameter blocks), 98304/SCALE (mid main) and 131072/SCALE (each of N_FULL full main blocks). With the top strap low, the order from address zero is boot, parameter, parameter, mid main, full mains. An erase clears exactly the block that holds the given address.
- R3: With the top strap high the map is mirrored, so word address a behaves as word TOTAL_W-1-a of the low layout. The boot block then occupies the highest words.
- R4: Program (0x40, then a data write) ANDs the data into only the addressed word or byte, so bits only go from 1 to 0.
- R5: Erase (0x20, then 0xD0 at an address in the block) sets every word of the block to 0xFFFF. Status bit 7 is low for exactly one cycle per word of the block, and for PROG_CYC cycles after a program.
- R6: A program or erase aimed at the boot block is refused when both wp_unlock and rp_unlock are low. A refused program sets status bit 4 and a refused erase sets bit 5. The data is left unchanged.
- R7: While vpp_low is high every program and erase is refused. Status bit 3 is set together with bit 4 (program) or bit 5 (erase), and the data is left unchanged.
- R8: Command codes are taken from din[7:0]. An unknown first command, or a second erase write other than 0xD0, sets status bits 5 and 4.
- R9: Error bits stay set across later successful operations until the 0x50 command clears them.
- R10: With byte_wide high at reset, din[15] selects the byte lane: 1 selects the high byte of the word at addr. Reads return the selected byte on dout[7:0] with dout[15:8] zero.
- R11: The status byte has bit 7 = ready, bit 5 = erase error, bit 4 = program error and bit 3 = voltage error; the other bits are zero. It appears on dout[7:0] after 0x70 and after any program or erase command. 0xFF returns to array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| boot_at_top | input | 1 | Strap: boot block at highest addresses when 1 |
| byte_wide | input | 1 | Strap: byte-wide access when 1, word-wide when 0 |
| wp_unlock | input | 1 | Write-protect release for the boot block |
| rp_unlock | input | 1 | Reset-pin override release for the boot block |
| vpp_low | input | 1 | Programming voltage below lockout; refuses all writes |
| we | input | 1 | Write strobe, one command or data write per high cycle |
| addr | input | AW | Word address |
| din | input | 16 | Write data / command; din[15] is the byte-lane bit in byte mode |
| dout | output | 16 | Array data or status byte |

## Verification
The bench builds the block with SCALE=2048, N_FULL=1 and PROG_CYC=3. This gives a 64-word array whose blocks hold 4, 2, 2, 24 and 32 words. Every block class can therefore be erased in a few dozen cycles, and the busy length of each one is counted exactly. The small map also lets both strap orders and both widths be reset into within one run, with the same stored words checked against the mirrored decode.

// File: rtl/bbf_pkg.sv
package bbf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PSET,
    ST_ESET,
    ST_PROG,
    ST_ERASE
  } wsm_state_t;

  localparam logic [7:0] CMD_READ    = 8'hFF;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;

  // words in block i, low-layout order: boot, param, param, mid, full...
  function automatic int unsigned blk_words(int unsigned scale, int unsigned i);
    if (i == 0) return 8192 / scale;
    if (i < 3) return 4096 / scale;
    if (i == 3) return 49152 / scale;
    return 65536 / scale;
  endfunction

  function automatic int unsigned blk_first(int unsigned scale, int unsigned i);
    int unsigned s;
    s = 0;
    for (int unsigned j = 0; j < i; j++) s += blk_words(scale, j);
    return s;
  endfunction

  function automatic int unsigned total_words(int unsigned scale, int unsigned nfull);
    return blk_first(scale, 4 + nfull);
  endfunction

endpackage

// File: rtl/bbf_block_map.sv
module bbf_block_map import bbf_pkg::*; #(
  parameter int unsigned SCALE   = 1024,
  parameter int unsigned N_FULL  = 3,
  parameter int unsigned TOTAL_W = 256,
  parameter int unsigned AW      = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          top,
  output logic          hit_any,
  output logic          is_boot,
  output logic [AW-1:0] base,
  output logic [AW:0]   len
);

  localparam int unsigned NBLK = 4 + N_FULL;

  logic [AW:0]   mir;
  logic [NBLK-1:0] hit;
  logic [AW-1:0] base_v [NBLK];
  logic [AW:0]   len_v  [NBLK];

  // top layout is the low layout read backwards
  assign mir = top ? ((AW+1)'(TOTAL_W - 1) - {1'b0, addr}) : {1'b0, addr};

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    localparam int unsigned LO = blk_first(SCALE, g);
    localparam int unsigned SZ = blk_words(SCALE, g);
    assign hit[g]    = (mir >= (AW+1)'(LO)) && (mir < (AW+1)'(LO + SZ));
    assign len_v[g]  = (AW+1)'(SZ);
    assign base_v[g] = top ? AW'(TOTAL_W - LO - SZ) : AW'(LO);
  end

  always_comb begin
    base = '0;
    len  = '0;
    for (int i = 0; i < NBLK; i++) begin
      if (hit[i]) begin
        base = base_v[i];
        len  = len_v[i];
      end
    end
  end

  assign hit_any = |hit;
  assign is_boot = hit[0];

endmodule

// File: rtl/bbf_array.sv
module bbf_array #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8
) (
  input  logic          clk,
  input  logic          prog,
  input  logic          erase,
  input  logic [AW-1:0] wa,
  input  logic [15:0]   wd,
  input  logic [1:0]    be,
  input  logic [AW-1:0] ra,
  output logic [15:0]   rd
);

  logic [15:0] mem [DEPTH];
  logic [15:0] pmask;

  // lanes not enabled keep their bits (AND with ones)
  assign pmask = {be[1] ? wd[15:8] : 8'hFF, be[0] ? wd[7:0] : 8'hFF};

  always_ff @(posedge clk) begin
    if (erase)     mem[wa] <= 16'hFFFF;
    else if (prog) mem[wa] <= mem[wa] & pmask;
  end

  assign rd = mem[ra];

endmodule

// File: rtl/bootblk_flash.sv
module bootblk_flash import bbf_pkg::*; #(
  parameter int unsigned SCALE    = 1024,
  parameter int unsigned N_FULL   = 3,
  parameter int unsigned PROG_CYC = 4,
  localparam int unsigned TOTAL_W = total_words(SCALE, N_FULL),
  localparam int unsigned AW      = $clog2(TOTAL_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_at_top,
  input  logic          byte_wide,
  input  logic          wp_unlock,
  input  logic          rp_unlock,
  input  logic          vpp_low,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   din,
  output logic [15:0]   dout
);

  localparam int unsigned CW = $clog2(TOTAL_W + PROG_CYC + 1);

  // reset release synchronizer
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // straps captured on the first cycle out of reset
  logic cfg_done, byte_q, top_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cfg_done <= 1'b0;
      byte_q   <= 1'b0;
      top_q    <= 1'b0;
    end else if (!cfg_done) begin
      cfg_done <= 1'b1;
      byte_q   <= byte_wide;
      top_q    <= boot_at_top;
    end
  end

  // block decode of the host address
  logic          blk_hit, blk_boot;
  logic [AW-1:0] blk_base;
  logic [AW:0]   blk_len;

  bbf_block_map #(.SCALE(SCALE), .N_FULL(N_FULL), .TOTAL_W(TOTAL_W), .AW(AW)) u_map (
    .addr    (addr),
    .top     (top_q),
    .hit_any (blk_hit),
    .is_boot (blk_boot),
    .base    (blk_base),
    .len     (blk_len)
  );

  // command interface and write state machine
  wsm_state_t    state, state_n;
  logic          stat_mode, stat_n;
  logic          err_e, err_p, err_v, ee_n, ep_n, ev_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [AW-1:0] ptr, ptr_n;
  logic          arr_prog, arr_erase;
  logic          cmd_wr, busy, boot_locked;
  logic [7:0]    cmd;

  assign cmd         = din[7:0];
  assign cmd_wr      = we & cfg_done;
  assign busy        = (state == ST_PROG) || (state == ST_ERASE);
  assign boot_locked = blk_boot & ~(wp_unlock | rp_unlock);

  always_comb begin
    state_n   = state;
    stat_n    = stat_mode;
    ee_n      = err_e;
    ep_n      = err_p;
    ev_n      = err_v;
    cnt_n     = cnt;
    ptr_n     = ptr;
    arr_prog  = 1'b0;
    arr_erase = 1'b0;
    unique case (state)
      ST_IDLE: if (cmd_wr) begin
        unique case (cmd)
          CMD_READ:   stat_n = 1'b0;
          CMD_STATUS: stat_n = 1'b1;
          CMD_CLEAR:  begin ee_n = 1'b0; ep_n = 1'b0; ev_n = 1'b0; end
          CMD_PROG:   begin state_n = ST_PSET; stat_n = 1'b1; end
          CMD_ERASE:  begin state_n = ST_ESET; stat_n = 1'b1; end
          default:    begin ee_n = 1'b1; ep_n = 1'b1; stat_n = 1'b1; end
        endcase
      end
      ST_PSET: if (cmd_wr) begin
        state_n = ST_IDLE;
        if (vpp_low) begin
          ev_n = 1'b1;
          ep_n = 1'b1;
        end else if (boot_locked || !blk_hit) begin
          ep_n = 1'b1;
        end else begin
          arr_prog = 1'b1;
          state_n  = ST_PROG;
          cnt_n    = CW'(PROG_CYC - 1);
        end
      end
      ST_ESET: if (cmd_wr) begin
        state_n = ST_IDLE;
        if (cmd != CMD_CONFIRM) begin
          ee_n = 1'b1;
          ep_n = 1'b1;
        end else if (vpp_low) begin
          ev_n = 1'b1;
          ee_n = 1'b1;
        end else if (boot_locked || !blk_hit) begin
          ee_n = 1'b1;
        end else begin
          state_n = ST_ERASE;
          ptr_n   = blk_base;
          cnt_n   = CW'(blk_len) - CW'(1);
        end
      end
      ST_PROG: begin
        if (cnt == '0) state_n = ST_IDLE;
        else           cnt_n   = cnt - CW'(1);
      end
      ST_ERASE: begin
        arr_erase = 1'b1;
        ptr_n     = ptr + AW'(1);
        if (cnt == '0) state_n = ST_IDLE;
        else           cnt_n   = cnt - CW'(1);
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state     <= ST_IDLE;
      stat_mode <= 1'b0;
      err_e     <= 1'b0;
      err_p     <= 1'b0;
      err_v     <= 1'b0;
      cnt       <= '0;
      ptr       <= '0;
    end else begin
      state     <= state_n;
      stat_mode <= stat_n;
      err_e     <= ee_n;
      err_p     <= ep_n;
      err_v     <= ev_n;
      cnt       <= cnt_n;
      ptr       <= ptr_n;
    end
  end

  // storage and read path
  logic        lane;
  logic [15:0] wr_data, arr_rd;
  logic [1:0]  wr_be;
  logic [7:0]  sr;

  assign lane    = din[15];
  assign wr_data = byte_q ? {din[7:0], din[7:0]} : din;
  assign wr_be   = byte_q ? (lane ? 2'b10 : 2'b01) : 2'b11;

  bbf_array #(.DEPTH(TOTAL_W), .AW(AW)) u_arr (
    .clk   (clk),
    .prog  (arr_prog),
    .erase (arr_erase),
    .wa    ((state == ST_ERASE) ? ptr : addr),
    .wd    (wr_data),
    .be    (wr_be),
    .ra    (addr),
    .rd    (arr_rd)
  );

  assign sr   = {~busy, 1'b0, err_e, err_p, err_v, 3'b000};
  assign dout = stat_mode ? {8'h00, sr}
              : (byte_q ? {8'h00, (lane ? arr_rd[15:8] : arr_rd[7:0])} : arr_rd);

endmodule

// File: rtl/bootblk_flash_chk.sv
module bootblk_flash_chk import bbf_pkg::*; (
  input logic        clk,
  input logic        rst_i_n,
  input logic        cmd_wr,
  input logic [15:0] din,
  input logic        vpp_low,
  input logic        boot_locked,
  input wsm_state_t  state,
  input logic        busy,
  input logic        stat_mode,
  input logic        err_v,
  input logic        err_p,
  input logic        err_e,
  input logic [15:0] dout
);

  // R7
  vpp_refuse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_wr && state == ST_PSET && vpp_low) |=> (err_v && err_p && !busy));

  // R6
  boot_refuse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_wr && state == ST_PSET && !vpp_low && boot_locked) |=> (err_p && !busy));

  // R8
  seq_err_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_wr && state == ST_ESET && din[7:0] != CMD_CONFIRM) |=> (err_e && err_p));

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (err_v && !(cmd_wr && state == ST_IDLE && din[7:0] == CMD_CLEAR)) |=> err_v);

  // R11
  busy_status_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |-> (stat_mode && !dout[7]));

endmodule

bind bootblk_flash bootblk_flash_chk u_chk (
  .clk         (clk),
  .rst_i_n     (rst_i_n),
  .cmd_wr      (cmd_wr),
  .din         (din),
  .vpp_low     (vpp_low),
  .boot_locked (boot_locked),
  .state       (state),
  .busy        (busy),
  .stat_mode   (stat_mode),
  .err_v       (err_v),
  .err_p       (err_p),
  .err_e       (err_e),
  .dout        (dout)
);

// File: tb/tb_bootblk_flash.sv
`timescale 1ns/1ps
module tb_bootblk_flash;

  localparam int SCALE = 2048, N_FULL = 1, PROG_CYC = 3;
  localparam int AW = 6;   // 4+2+2+24+32 = 64 words

  logic          clk = 1'b0;
  logic          rst_n, boot_at_top, byte_wide, wp_unlock, rp_unlock, vpp_low, we;
  logic [AW-1:0] addr;
  logic [15:0]   din, dout;

  always #2 clk = ~clk;

  bootblk_flash #(.SCALE(SCALE), .N_FULL(N_FULL), .PROG_CYC(PROG_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .boot_at_top(boot_at_top), .byte_wide(byte_wide),
    .wp_unlock(wp_unlock), .rp_unlock(rp_unlock), .vpp_low(vpp_low), .we(we),
    .addr(addr), .din(din), .dout(dout)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; din = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic lane, output logic [15:0] v);
    @(negedge clk); addr = a; din = {lane, 15'h0};
    #1 v = dout;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    #1;
    while (!dout[7] && n < 2000) begin
      @(negedge clk); #1; n++;
    end
  endtask

  task automatic prog_op(input logic [AW-1:0] a, input logic [15:0] d,
                         output logic [15:0] st, output int n);
    wr(a, 16'h0040); wr(a, d); wait_ready(n); st = dout;
  endtask

  task automatic erase_op(input logic [AW-1:0] a, output logic [15:0] st, output int n);
    wr(a, 16'h0020); wr(a, 16'h00D0); wait_ready(n); st = dout;
  endtask

  task automatic do_reset(input logic top, input logic bw);
    @(negedge clk); rst_n = 1'b0; boot_at_top = top; byte_wide = bw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  k;
    logic [3:0]  req;
    logic [5:0]  a;
    logic [15:0] d;
  } vec_t;

  localparam logic [1:0] K_W = 2'd0, K_R = 2'd1, K_S = 2'd2;
  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{K_W, 4'd4,  6'd5, 16'h0040},  // R4 program word 5
    '{K_W, 4'd4,  6'd5, 16'hA5F0},
    '{K_S, 4'd11, 6'd0, 16'h0080},  // R11 ready, no error
    '{K_W, 4'd11, 6'd0, 16'h00FF},
    '{K_R, 4'd4,  6'd5, 16'hA5F0},  // R4 data written
    '{K_R, 4'd4,  6'd4, 16'hFFFF},  // R4 neighbour untouched
    '{K_W, 4'd4,  6'd5, 16'h0040},
    '{K_W, 4'd4,  6'd5, 16'h0FFF},
    '{K_S, 4'd4,  6'd0, 16'h0080},
    '{K_W, 4'd4,  6'd0, 16'h00FF},
    '{K_R, 4'd4,  6'd5, 16'h05F0},  // R4 AND with stored data
    '{K_W, 4'd2,  6'd7, 16'h0040},
    '{K_W, 4'd2,  6'd7, 16'h1234},
    '{K_S, 4'd2,  6'd0, 16'h0080},
    '{K_W, 4'd2,  6'd8, 16'h0040},
    '{K_W, 4'd2,  6'd8, 16'h5678},
    '{K_S, 4'd2,  6'd0, 16'h0080},
    '{K_W, 4'd2,  6'd6, 16'h0020},  // R2 erase second parameter block
    '{K_W, 4'd2,  6'd6, 16'h00D0},
    '{K_S, 4'd2,  6'd0, 16'h0080},
    '{K_W, 4'd2,  6'd0, 16'h00FF},
    '{K_R, 4'd2,  6'd7, 16'hFFFF},  // R2 whole block erased
    '{K_R, 4'd2,  6'd6, 16'hFFFF},
    '{K_R, 4'd2,  6'd8, 16'h5678},  // R2 mid block untouched
    '{K_R, 4'd2,  6'd5, 16'h05F0},  // R2 first parameter block untouched
    '{K_W, 4'd11, 6'd0, 16'h0070},  // R11 read status
    '{K_R, 4'd11, 6'd9, 16'h0080},
    '{K_W, 4'd11, 6'd0, 16'h00FF},
    '{K_R, 4'd11, 6'd7, 16'hFFFF}   // R11 back to array
  };

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, st;
    int n;
    rst_n = 1'b0; boot_at_top = 1'b0; byte_wide = 1'b0;
    wp_unlock = 1'b1; rp_unlock = 1'b0; vpp_low = 1'b0;
    we = 1'b0; addr = '0; din = '0;
    do_reset(1'b0, 1'b0);

    // bring every block to the erased state (bottom layout)
    erase_op(6'd0, st, n);  chk("R5 boot erase cycles", 16'(n), 16'd4);
    erase_op(6'd4, st, n);  chk("R2 param0 erase cycles", 16'(n), 16'd2);
    erase_op(6'd6, st, n);
    erase_op(6'd8, st, n);  chk("R2 mid erase cycles", 16'(n), 16'd24);
    erase_op(6'd32, st, n);
    wr(6'd0, 16'h00FF);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].k)
        K_W: wr(VEC[i].a, VEC[i].d);
        K_R: begin
          rd(VEC[i].a, 1'b0, v);
          chk($sformatf("R%0d table %0d", VEC[i].req, i), v, VEC[i].d);
        end
        default: begin
          wait_ready(n);
          chk($sformatf("R%0d table %0d", VEC[i].req, i), dout, VEC[i].d);
        end
      endcase
    end

    // R5 busy lengths and full-block erase
    prog_op(6'd31, 16'h0000, st, n);
    chk("R5 program busy cycles", 16'(n), 16'(PROG_CYC));
    prog_op(6'd32, 16'h0000, st, n);
    erase_op(6'd40, st, n);
    chk("R5 full block busy cycles", 16'(n), 16'd32);
    chk("R5 erase status", st, 16'h0080);
    wr(6'd0, 16'h00FF);
    rd(6'd32, 1'b0, v); chk("R5 full block first word", v, 16'hFFFF);
    rd(6'd63, 1'b0, v); chk("R5 full block last word", v, 16'hFFFF);
    rd(6'd31, 1'b0, v); chk("R2 mid block keeps data", v, 16'h0000);

    // R6 boot block lock
    wp_unlock = 1'b0; rp_unlock = 1'b0;
    prog_op(6'd2, 16'h0000, st, n);
    chk("R6 locked program status", st, 16'h0090);
    wr(6'd0, 16'h0050);
    erase_op(6'd1, st, n);
    chk("R6 locked erase status", st, 16'h00A0);
    wr(6'd0, 16'h00FF);
    rd(6'd2, 1'b0, v); chk("R6 locked data unchanged", v, 16'hFFFF);
    wr(6'd0, 16'h0050);
    rp_unlock = 1'b1;
    prog_op(6'd2, 16'h00F0, st, n);
    chk("R6 reset-pin unlock program", st, 16'h0080);
    rp_unlock = 1'b0; wp_unlock = 1'b1;
    erase_op(6'd3, st, n);
    chk("R6 write-protect unlock erase", st, 16'h0080);
    wr(6'd0, 16'h00FF);
    rd(6'd2, 1'b0, v); chk("R6 boot erased", v, 16'hFFFF);

    // R7 voltage lockout
    vpp_low = 1'b1;
    wr(6'd0, 16'h0050);
    prog_op(6'd5, 16'h0000, st, n);
    chk("R7 program refused status", st, 16'h0098);
    wr(6'd0, 16'h0050);
    erase_op(6'd5, st, n);
    chk("R7 erase refused status", st, 16'h00A8);
    vpp_low = 1'b0;
    wr(6'd0, 16'h00FF);
    rd(6'd5, 1'b0, v); chk("R7 data unchanged", v, 16'h05F0);

    // R8 bad command sequences
    wr(6'd0, 16'h0050);
    wr(6'd0, 16'h0033);
    rd(6'd0, 1'b0, v); chk("R8 unknown command", v, 16'h00B0);
    wr(6'd0, 16'h0050);
    wr(6'd5, 16'h0020); wr(6'd5, 16'h0099);
    rd(6'd0, 1'b0, v); chk("R8 bad erase confirm", v, 16'h00B0);
    wr(6'd0, 16'h00FF);
    rd(6'd5, 1'b0, v); chk("R8 no erase done", v, 16'h05F0);

    // R9 sticky errors
    wr(6'd0, 16'h0050);
    wr(6'd0, 16'h0033);
    prog_op(6'd9, 16'h0F0F, st, n);
    chk("R9 error kept after good program", st, 16'h00B0);
    wr(6'd0, 16'h0050);
    rd(6'd0, 1'b0, v); chk("R9 cleared by 0x50", v, 16'h0080);
    wr(6'd0, 16'h00FF);
    rd(6'd9, 1'b0, v); chk("R9 program done", v, 16'h0F0F);

    // R1 reset state
    do_reset(1'b0, 1'b0);
    rd(6'd5, 1'b0, v); chk("R1 array mode after reset", v, 16'h05F0);
    wr(6'd0, 16'h0070);
    rd(6'd0, 1'b0, v); chk("R1 status after reset", v, 16'h0080);

    // R3 top layout
    do_reset(1'b1, 1'b0);
    erase_op(6'd62, st, n);
    chk("R3 top boot erase cycles", 16'(n), 16'd4);
    prog_op(6'd63, 16'h0000, st, n);
    prog_op(6'd59, 16'h1111, st, n);
    erase_op(6'd60, st, n);
    wr(6'd0, 16'h00FF);
    rd(6'd63, 1'b0, v); chk("R3 top boot erased", v, 16'hFFFF);
    rd(6'd59, 1'b0, v); chk("R3 top param kept", v, 16'h1111);
    erase_op(6'd33, st, n);
    chk("R3 top mid erase cycles", 16'(n), 16'd24);
    wp_unlock = 1'b0;
    prog_op(6'd61, 16'h0000, st, n);
    chk("R3 top boot locked", st, 16'h0090);
    wr(6'd0, 16'h0050);
    prog_op(6'd3, 16'h0000, st, n);
    chk("R3 low words not boot in top layout", st, 16'h0080);
    wp_unlock = 1'b1;

    // R10 byte mode
    do_reset(1'b0, 1'b1);
    erase_op(6'd10, st, n);
    prog_op(6'd10, 16'h803C, st, n);
    chk("R10 byte program status", st, 16'h0080);
    wr(6'd0, 16'h00FF);
    rd(6'd10, 1'b1, v); chk("R10 high lane", v, 16'h003C);
    rd(6'd10, 1'b0, v); chk("R10 low lane", v, 16'h00FF);
    do_reset(1'b0, 1'b0);
    rd(6'd10, 1'b0, v); chk("R10 word view of byte write", v, 16'h3CFF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule